// File: doc/BRIEF.md
# I2C Burst Transmit Engine

This block is an I2C master sequencer that a host runs through a small register window. The host can request a START condition or a STOP condition on its own. It can also preload a transmit buffer of eight 32-bit words and then write a byte count to send the buffered bytes as one burst. The first buffered byte is normally the slave address with the write bit clear. After every byte the engine releases SDA for a ninth clock and samples the slave's acknowledge. A NAK ends the burst at once. Progress is reported through sticky pending flags, which can be cleared by writing 1 to them, and a per-flag enable mask that feeds one interrupt line.

The bus is driven open-drain: `scl_oe` and `sda_oe` pull their line low when high. All bus timing comes from a `tick` strobe, and every bus phase takes exactly one tick. A byte takes 28 ticks: three per data bit (SCL low, set SDA, SCL high) and four for the acknowledge bit, whose last tick samples SDA and drops SCL. START and STOP take four ticks each.

Top module: `i2c_burst_tx`

## Requirements
- R1: After reset both line enables are 0, `irq` is 0, and the control, count, enable, pending and buffer registers read 0.
- R2: Control register (offset 0x000): bit 0 enable, bits 2:1 mode (stored, read back), bit 3 START, bit 4 STOP, bit 5 ACK and bit 6 stop-on-NAK (stored, read back). While enabled and idle, a set START bit makes the engine take SDA low while SCL is high and then take SCL low. The START bit clears itself and pending bit 4 is set 5 cycles after the write, when `tick` is high every cycle.
- R3: While enabled and idle, a set STOP bit drives both lines low, releases SCL and then releases SDA while SCL is high. The STOP bit clears itself and pending bit 5 is set 5 cycles after the write, when `tick` is high every cycle.
- R4: Writing a nonzero count N to offset 0x010 while enabled and idle sends N buffered bytes. The buffer words are at 0x100 + 4k. Bytes are taken low byte of word 0 first, in little-endian order, and each byte is sent MSB first.
- R5: When the last byte of a burst is acknowledged, pending bit 2 is set, 28·N cycles after the count write when `tick` is high every cycle.
- R6: A NAK (SDA high on the ninth clock) sets pending bit 6 at that byte's acknowledge tick. The remaining bytes are not sent, pending bit 2 stays clear, SCL is held low, and a later STOP request still completes.
- R7: Pending flags (offset 0x01C) stay set until a 1 is written to their bit. Writing 0 has no effect.
- R8: `irq` is high exactly when some pending flag is set whose bit is also set in the enable register at 0x018. Only bits 2, 4, 5 and 6 are implemented.
- R9: Clearing the enable bit returns the engine to idle and releases both lines one cycle later. While disabled, a count write and the START and STOP bits start nothing.
- R10: Without `tick` no bus phase advances: a requested START sets no flag and moves no line.
- R11: If START and STOP are both set in one write, the START condition is generated first and the STOP condition follows. Pending bit 5 is set 10 cycles after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bus phase strobe; one bus phase per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | OR of the enabled pending flags |

## Verification
With `tick` held high, the bench knows the exact cycle of each result. A START or STOP flag is due 5 cycles after its control write, or 10 cycles for a combined request. A burst-done flag is due 28·N cycles after the count write, and a NAK flag 28·(k+1) cycles after it for a NAK on byte k. A line release is due one cycle after the enable bit is cleared. For each of these flags the bench samples at the falling clock edge one cycle before the due edge, expecting the flag clear, and again just after the due edge, expecting it set. A bus-level slave model watches the lines at falling clock edges to decode START, STOP and data bits, and it drives the acknowledge or a NAK at a chosen byte.

// File: rtl/i2c_burst_tx.sv
module i2c_burst_tx #(
  parameter int BUF_WORDS = 8,
  parameter int CNT_W     = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_we,
  input  logic [9:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  localparam int WIX = $clog2(BUF_WORDS);
  localparam int IDX_W = WIX + 2;
  localparam logic [9:0] A_CTRL = 10'h000;
  localparam logic [9:0] A_CNT  = 10'h010;
  localparam logic [9:0] A_IEN  = 10'h018;
  localparam logic [9:0] A_PEND = 10'h01C;
  localparam logic [6:0] FLAG_MASK = 7'h74;

  typedef enum logic [1:0] {S_IDLE, S_START, S_STOP, S_BIT} st_t;

  st_t              st;
  logic [6:0]       ctrl, ien, pend;
  logic [CNT_W-1:0] cnt_q, left;
  logic [IDX_W-1:0] idx, nidx;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh, nbyte;
  logic             scl_lo, sda_lo;
  logic [31:0]      txbuf [BUF_WORDS];

  wire en      = ctrl[0];
  wire ctrl_wr = reg_we && reg_addr == A_CTRL;
  wire cnt_wr  = reg_we && reg_addr == A_CNT;
  wire pend_wr = reg_we && reg_addr == A_PEND;
  wire buf_hit = reg_addr[9:8] == 2'b01 && reg_addr[1:0] == 2'b00 &&
                 reg_addr[7:2] < 6'(BUF_WORDS);

  wire done_start = st == S_START && tick && ph == 2'd3;
  wire done_stop  = st == S_STOP  && tick && ph == 2'd3;
  wire ack_eval   = st == S_BIT   && tick && ph == 2'd3 && bitn == 4'd8;
  wire got_nak    = ack_eval && sda_in;
  wire burst_done = ack_eval && !sda_in && left == CNT_W'(1);

  wire [6:0] pend_set = {got_nak, done_stop, done_start, 1'b0, burst_done, 2'b00};
  wire [6:0] pend_clr = pend_wr ? (reg_wdata[6:0] & FLAG_MASK) : 7'h0;

  assign nidx   = idx + IDX_W'(1);
  assign nbyte  = txbuf[nidx[IDX_W-1:2]][{nidx[1:0], 3'b000} +: 8];
  assign scl_oe = scl_lo;
  assign sda_oe = sda_lo;
  assign irq    = |(pend & ien);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {25'b0, ctrl};
      A_CNT:   reg_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      A_IEN:   reg_rdata = {25'b0, ien};
      A_PEND:  reg_rdata = {25'b0, pend};
      default: reg_rdata = buf_hit ? txbuf[reg_addr[2 +: WIX]] : 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_WORDS; i++) txbuf[i] <= '0;
    end else if (reg_we && buf_hit) begin
      txbuf[reg_addr[2 +: WIX]] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      ien   <= '0;
      pend  <= '0;
      cnt_q <= '0;
    end else begin
      pend <= (pend & ~pend_clr) | pend_set;
      if (reg_we && reg_addr == A_IEN) ien <= reg_wdata[6:0] & FLAG_MASK;
      if (cnt_wr) cnt_q <= reg_wdata[CNT_W-1:0];
      if (ctrl_wr) ctrl <= reg_wdata[6:0];
      else begin
        if (done_start) ctrl[3] <= 1'b0;
        if (done_stop)  ctrl[4] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= '0;
      bitn   <= '0;
      idx    <= '0;
      left   <= '0;
      sh     <= '0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else if (!en) begin
      st     <= S_IDLE;
      ph     <= '0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          ph <= '0;
          if (cnt_wr && reg_wdata[CNT_W-1:0] != '0) begin
            st   <= S_BIT;
            bitn <= '0;
            idx  <= '0;
            left <= reg_wdata[CNT_W-1:0];
            sh   <= txbuf[0][7:0];
          end else if (ctrl[3]) st <= S_START;
          else if (ctrl[4])     st <= S_STOP;
        end
        S_START: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: begin scl_lo <= 1'b1; st <= S_IDLE; end
          endcase
        end
        S_STOP: if (tick) begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: scl_lo <= 1'b1;
            2'd1: sda_lo <= 1'b1;
            2'd2: scl_lo <= 1'b0;
            default: begin sda_lo <= 1'b0; st <= S_IDLE; end
          endcase
        end
        default: if (tick) begin
          case (ph)
            2'd0: begin scl_lo <= 1'b1; ph <= 2'd1; end
            2'd1: begin
              sda_lo <= (bitn < 4'd8) ? ~sh[7] : 1'b0;
              ph     <= 2'd2;
            end
            2'd2: begin
              scl_lo <= 1'b0;
              if (bitn < 4'd8) begin
                ph   <= 2'd0;
                bitn <= bitn + 4'd1;
                sh   <= {sh[6:0], 1'b0};
              end else ph <= 2'd3;
            end
            default: begin
              scl_lo <= 1'b1;
              ph     <= 2'd0;
              if (sda_in || left == CNT_W'(1)) st <= S_IDLE;
              else begin
                left <= left - CNT_W'(1);
                idx  <= nidx;
                sh   <= nbyte;
                bitn <= '0;
              end
            end
          endcase
        end
      endcase
    end
  end

  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_oe && !sda_oe)); // R9

  AST_SDA_FALL_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe && !$past(scl_oe)) |-> $past(st) == S_START); // R2

  AST_SDA_RISE_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && !scl_oe && !$past(scl_oe)) |->
      ($past(st) == S_STOP || $past(st) == S_START || !$past(en))); // R3

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend) & ~pend)) |-> $past(pend_wr)); // R7

  AST_DONE_FROM_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[2]) |-> $past(st) == S_BIT); // R5

  AST_NAK_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[6]) |-> st == S_IDLE); // R6
endmodule

// File: tb/tb_i2c_burst_tx.sv
module tb_i2c_burst_tx;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] A_CTRL = 10'h000, A_CNT = 10'h010,
                         A_IEN = 10'h018, A_PEND = 10'h01C;
  localparam logic [11:0] VEC [4] = '{{6'd1, 6'd63}, {6'd5, 6'd63},
                                      {6'd32, 6'd63}, {6'd6, 6'd2}};

  logic clk = 0, rst_n = 0, tick = 0, reg_we = 0, slv_pull = 0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic scl_oe, sda_oe, irq, sda_in;
  int total = 0, fails = 0, start_cnt = 0, stop_cnt = 0, nrx = 0, nak_at = 99;
  int bitc = 0, order = 0;
  logic ackph = 0, pscl = 1, psda = 1;
  logic [7:0] shr = 0;
  logic [7:0] rxb [64];

  assign sda_in = !(sda_oe || slv_pull);
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_burst_tx dut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  always @(negedge clk) begin
    automatic logic scl = !scl_oe;
    automatic logic sda = !(sda_oe || slv_pull);
    if (scl && pscl && psda && !sda) begin
      start_cnt++; order = order * 10 + 1; bitc = 0; ackph = 0;
    end
    if (scl && pscl && !psda && sda) begin stop_cnt++; order = order * 10 + 2; end
    if (scl && !pscl && !ackph && bitc < 8) begin
      shr = {shr[6:0], sda}; bitc++;
      if (bitc == 8) begin rxb[nrx[5:0]] = shr; nrx++; end
    end
    if (!scl && pscl) begin
      if (ackph) begin slv_pull = 0; ackph = 0; bitc = 0; end
      else if (bitc == 8) begin slv_pull = (nrx - 1 != nak_at); ackph = 1; end
    end
    pscl = scl; psda = !(sda_oe || slv_pull);
  end

  function automatic logic [7:0] pat(int v, int i);
    if (i == 0) return {7'h50 + 7'(v), 1'b0};
    return 8'(i * 29 + v * 71 + 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wt(3); rst_n = 1; wt(1);
    check("R1 lines", {scl_oe, sda_oe, irq}, 3'b000);
    rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
    rd(A_PEND, rv); check("R1 pend", rv, 0);
    rd(10'h104, rv); check("R1 buf", rv, 0);

    wr(A_CTRL, 32'h09); wt(30);
    rd(A_PEND, rv); check("R10 no flag without tick", rv, 0);
    check("R10 lines idle", {scl_oe, sda_oe, 6'(start_cnt)}, 0);
    wr(A_CTRL, 0); wt(2);

    tick = 1;
    wr(A_CTRL, 32'h09); wt(4);
    rd(A_PEND, rv); check("R2 flag not early", rv, 0);
    wt(1); rd(A_PEND, rv); check("R2 start flag", rv, 32'h10);
    check("R2 start seen", start_cnt, 1);
    rd(A_CTRL, rv); check("R2 start bit self-clears", rv, 32'h01);

    wr(A_PEND, 0); rd(A_PEND, rv); check("R7 write 0 keeps", rv, 32'h10);
    check("R8 irq masked", irq, 0);
    wr(A_IEN, 32'h10); check("R8 irq enabled", irq, 1);
    wr(A_IEN, 32'h04); check("R8 other enable", irq, 0);
    wr(A_PEND, 32'h10); rd(A_PEND, rv); check("R7 w1c clears", rv, 0);
    wr(A_IEN, 0);

    for (int v = 0; v < 4; v++) begin
      automatic int n = int'(VEC[v][11:6]);
      automatic int k = int'(VEC[v][5:0]);
      automatic bit nk = (k < n);
      automatic int sent = nk ? k + 1 : n;
      automatic int bad = 0;
      if (v > 0) begin wr(A_CTRL, 32'h09); wt(6); wr(A_PEND, 32'h10); end
      for (int w = 0; w < 8; w++)
        wr(10'h100 + 10'(4 * w), {pat(v, 4*w+3), pat(v, 4*w+2), pat(v, 4*w+1), pat(v, 4*w)});
      nak_at = nk ? k : 99; nrx = 0;
      wr(A_CNT, 32'(n));
      wt(28 * sent - 1);
      rd(A_PEND, rv); check(nk ? "R6 nak not early" : "R5 done not early", rv, 0);
      wt(1);
      rd(A_PEND, rv); check(nk ? "R6 nak flag" : "R5 done flag", rv, nk ? 32'h40 : 32'h04);
      wt(60);
      check("R4 byte count", nrx, sent);
      for (int i = 0; i < sent; i++) if (rxb[i] !== pat(v, i)) bad++;
      check("R4 byte values", bad, 0);
      if (nk) check("R6 SCL held low", scl_oe, 1);
      wr(A_PEND, 32'h44);
      begin
        automatic int sc = stop_cnt;
        wr(A_CTRL, 32'h11); wt(4);
        rd(A_PEND, rv); check("R3 stop not early", rv, 0);
        wt(1); rd(A_PEND, rv); check("R3 stop flag", rv, 32'h20);
        check("R3 stop seen", stop_cnt, sc + 1);
        wr(A_PEND, 32'h20);
      end
    end

    wr(A_CTRL, 32'h09); wt(6); wr(A_PEND, 32'h10);
    nak_at = 99; nrx = 0;
    wr(A_CNT, 32'd10); wt(40);
    wr(A_CTRL, 0); wt(1);
    check("R9 lines released", {scl_oe, sda_oe}, 2'b00);
    begin
      automatic int r = nrx;
      wr(A_CNT, 32'd3); wt(100);
      check("R9 count ignored when off", nrx, r);
      check("R9 lines stay released", {scl_oe, sda_oe}, 2'b00);
      rd(A_PEND, rv); check("R9 no done flag", rv, 0);
    end

    order = 0;
    wr(A_CTRL, 32'h19); wt(5);
    rd(A_PEND, rv); check("R11 start first", rv, 32'h10);
    wt(5); rd(A_PEND, rv); check("R11 stop follows", rv, 32'h30);
    check("R11 order", order, 12);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule